// File: doc/BRIEF.md
# Bus-Watching Breakpoint Trigger Unit

This unit sits beside a processor core and watches its program-side and data-side memory buses. It raises debug actions when programmed conditions occur. No opcode is ever patched, so a breakpoint can sit on ROM or RAM code, on an operand word, on a data variable, or on a memory-mapped peripheral register.

The unit has three condition sources. An address comparator watches either bus for a chosen kind of access. A masked value comparator watches the data read or write bus. A 16-bit down-counter counts a selected event. A combine stage merges these sources into one breakpoint, and an action selector turns the breakpoint into one of four outputs: an interrupt request pulse, a trace-start pulse, a trace-stop pulse, or a held halt request.

Software programs the unit through a small write-only register port. Register 0 is control, 1 is the address compare value, 2 is the data compare value, 3 is the data mask, and 4 is the counter preload. A control write with the enable bit set is called an arming write.

Top module: `brk_unit`

## Requirements
- R1: The address trigger mode is control bits [3:1]. The codes are 0 off, 1 program fetch, 2 program read, 3 program write, and 4 any program access (fetch, read or write). A program-side mode matches only when `pab_i` equals the compare value during a strobe of the selected kind.
- R2: Address trigger codes 5, 6 and 7 match a data read, a data write, or either, when `xab_i` equals the compare value. Every data address is treated alike, including peripheral register addresses at the top of the map.
- R3: The data trigger mode is control bits [5:4]. The codes are 0 off, 1 read, 2 write, and 3 both. A read compares `rdata_i` during `x_rd_i` and a write compares `wdata_i` during `x_wr_i`. Only bits whose mask bit is 1 take part in the compare.
- R4: A matching bus cycle produces its action in the following clock cycle, never in the same cycle. Each pulse action lasts exactly one cycle.
- R5: The combine mode is control bits [8:6]. The codes are 0 address trigger alone, 1 data trigger alone, 2 both in the same cycle, and 3 either one.
- R6: Combine code 4 fires when the data trigger matches in a later cycle than an address trigger match. One firing consumes the armed state, and an arming write clears it.
- R7: Combine code 5 fires from the counter. An arming write loads the preload value. Each selected event decrements the count. The breakpoint fires once, when the count steps from 1 to 0, and the count then stays at 0. A preload of 0 never fires.
- R8: The counter event source is control bits [10:9]. The codes are 0 address trigger, 1 data trigger, 2 the `dbg_ev_i` pulse, and 3 the `ovf_ev_i` pulse. Events from sources that are not selected do not change the count.
- R9: The action is control bits [13:11]. The codes are 0 interrupt, 1 trace start, 2 trace stop, 3 halt, and 4 interrupt plus counter reload from the preload value. Only the selected output responds.
- R10: Halt stays asserted until a `halt_clr_i` pulse. After a halt, every trigger is ignored until the next arming write.
- R11: While the enable bit (control bit 0) is clear, including after reset, no action output asserts. Clearing the enable bit also drops a pending halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| pab_i | input | AW | Program address bus |
| p_fetch_i | input | 1 | Program fetch strobe |
| p_rd_i | input | 1 | Program read strobe |
| p_wr_i | input | 1 | Program write strobe |
| xab_i | input | AW | Data address bus |
| x_rd_i | input | 1 | Data read strobe |
| x_wr_i | input | 1 | Data write strobe |
| rdata_i | input | DW | Data read bus |
| wdata_i | input | DW | Data write bus |
| dbg_ev_i | input | 1 | Debug-event instruction pulse |
| ovf_ev_i | input | 1 | Overflow or saturation pulse |
| halt_clr_i | input | 1 | Releases a held halt |
| irq_o | output | 1 | Breakpoint interrupt request pulse |
| trc_start_o | output | 1 | Trace buffer start pulse |
| trc_stop_o | output | 1 | Trace buffer stop pulse |
| halt_o | output | 1 | Core halt request |

## Verification
A wrong comparator or mode decode shows at the action outputs one cycle after the bus cycle: a pulse goes missing or appears for the wrong strobe. A corrupt armed flag or count produces no visible error when it goes wrong. It only shows later, as a breakpoint that fires too early, too late, twice, or never, at the first qualifying event after the fault. A stuck halt lock shows as halt that does not return after the next arming write.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int CFG_AW = 3;
  localparam int CFG_DW = 32;

  localparam logic [CFG_AW-1:0] REG_CTRL    = 3'd0;
  localparam logic [CFG_AW-1:0] REG_T1_CMP  = 3'd1;
  localparam logic [CFG_AW-1:0] REG_T2_VAL  = 3'd2;
  localparam logic [CFG_AW-1:0] REG_T2_MASK = 3'd3;
  localparam logic [CFG_AW-1:0] REG_PRELOAD = 3'd4;

  typedef enum logic [2:0] {
    T1_OFF, T1_P_FETCH, T1_P_READ, T1_P_WRITE,
    T1_P_ANY, T1_X_READ, T1_X_WRITE, T1_X_ANY
  } t1_mode_e;

  typedef enum logic [1:0] {T2_OFF, T2_READ, T2_WRITE, T2_ANY} t2_mode_e;

  typedef enum logic [2:0] {
    CMB_T1, CMB_T2, CMB_AND, CMB_OR, CMB_SEQ, CMB_CNT, CMB_RSV6, CMB_RSV7
  } cmb_mode_e;

  typedef enum logic [1:0] {SRC_T1, SRC_T2, SRC_DBG, SRC_OVF} cnt_src_e;

  typedef enum logic [2:0] {
    ACT_IRQ, ACT_TRC_START, ACT_TRC_STOP, ACT_HALT,
    ACT_IRQ_RELOAD, ACT_RSV5, ACT_RSV6, ACT_RSV7
  } act_e;

  typedef struct packed {
    act_e      act;
    cnt_src_e  src;
    cmb_mode_e cmb;
    t2_mode_e  t2;
    t1_mode_e  t1;
    logic      en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/brk_addr_trig.sv
module brk_addr_trig
  import brk_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  t1_mode_e      mode_i,
  input  logic [AW-1:0] cmp_i,
  input  logic [AW-1:0] pab_i,
  input  logic          p_fetch_i,
  input  logic          p_rd_i,
  input  logic          p_wr_i,
  input  logic [AW-1:0] xab_i,
  input  logic          x_rd_i,
  input  logic          x_wr_i,
  output logic          hit_o
);

  logic p_eq, x_eq, match, hit_q;

  always_comb begin
    p_eq = (pab_i == cmp_i);
    x_eq = (xab_i == cmp_i);
    case (mode_i)
      T1_P_FETCH: match = p_eq & p_fetch_i;
      T1_P_READ:  match = p_eq & p_rd_i;
      T1_P_WRITE: match = p_eq & p_wr_i;
      T1_P_ANY:   match = p_eq & (p_fetch_i | p_rd_i | p_wr_i);
      T1_X_READ:  match = x_eq & x_rd_i;
      T1_X_WRITE: match = x_eq & x_wr_i;
      T1_X_ANY:   match = x_eq & (x_rd_i | x_wr_i);
      default:    match = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= en_i & match;
  end

  assign hit_o = hit_q;

  AST_T1_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p_fetch_i && !p_rd_i && !p_wr_i && !x_rd_i && !x_wr_i) |=> !hit_o); // R1

endmodule

// File: rtl/brk_data_trig.sv
module brk_data_trig #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          x_rd_i,
  input  logic          x_wr_i,
  output logic          hit_o
);

  localparam int NLANE = 2;

  logic [DW-1:0]    bus [NLANE];
  logic [NLANE-1:0] strb, lane_hit;
  logic             hit_q;

  assign bus[0] = rdata_i;
  assign bus[1] = wdata_i;
  assign strb   = {x_wr_i, x_rd_i};

  // lane 0 = read path, lane 1 = write path; mode bit p enables lane p
  for (genvar p = 0; p < NLANE; p++) begin : g_lane
    assign lane_hit[p] = strb[p] & mode_i[p] & ~|((bus[p] ^ val_i) & mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= en_i & |lane_hit;
  end

  assign hit_o = hit_q;

  AST_T2_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i[0] && x_rd_i && mask_i == '0) |=> hit_o); // R3

endmodule

// File: rtl/brk_evt_counter.sv
module brk_evt_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [CW-1:0] preload_i,
  input  logic          ev_i,
  output logic          fire_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (load_i)                       cnt_q <= preload_i;
    else if (en_i && ev_i && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign fire_o = en_i & ev_i & (cnt_q == ONE);

  AST_CNT_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> cnt_q == '0); // R7
  AST_CNT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !load_i) |=> !fire_o); // R7

endmodule

// File: rtl/brk_combine.sv
module brk_combine
  import brk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      act_i,
  input  logic      clr_arm_i,
  input  cmb_mode_e mode_i,
  input  logic      t1_i,
  input  logic      t2_i,
  input  logic      cnt_i,
  output logic      fire_o
);

  logic armed_q, f;

  always_comb begin
    case (mode_i)
      CMB_T1:  f = t1_i;
      CMB_T2:  f = t2_i;
      CMB_AND: f = t1_i & t2_i;
      CMB_OR:  f = t1_i | t2_i;
      CMB_SEQ: f = armed_q & t2_i;
      CMB_CNT: f = cnt_i;
      default: f = 1'b0;
    endcase
  end

  assign fire_o = act_i & f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              armed_q <= 1'b0;
    else if (clr_arm_i)                       armed_q <= 1'b0;
    else if (act_i && mode_i == CMB_SEQ) begin
      if (t1_i)        armed_q <= 1'b1;
      else if (fire_o) armed_q <= 1'b0;
    end
  end

  AST_ARM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_arm_i |=> !armed_q); // R6

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic [AW-1:0]     pab_i,
  input  logic              p_fetch_i,
  input  logic              p_rd_i,
  input  logic              p_wr_i,
  input  logic [AW-1:0]     xab_i,
  input  logic              x_rd_i,
  input  logic              x_wr_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              dbg_ev_i,
  input  logic              ovf_ev_i,
  input  logic              halt_clr_i,
  output logic              irq_o,
  output logic              trc_start_o,
  output logic              trc_stop_o,
  output logic              halt_o
);

  ctrl_t         ctrl_q;
  logic [AW-1:0] t1_cmp_q;
  logic [DW-1:0] t2_val_q, t2_mask_q;
  logic [CW-1:0] preload_q;
  logic          halt_q, lock_q, dbg_q, ovf_q;
  logic          ctrl_wr, arm_wr, active;
  logic          t1_hit, t2_hit, cnt_ev, cnt_fire, cmb_fire;
  logic          halt_set, cnt_reload;

  assign ctrl_wr = cfg_we_i && cfg_addr_i == REG_CTRL;
  assign arm_wr  = ctrl_wr && cfg_wdata_i[0];
  assign active  = ctrl_q.en & ~lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      t1_cmp_q  <= '0;
      t2_val_q  <= '0;
      t2_mask_q <= '0;
      preload_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        REG_CTRL:    ctrl_q    <= ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
        REG_T1_CMP:  t1_cmp_q  <= cfg_wdata_i[AW-1:0];
        REG_T2_VAL:  t2_val_q  <= cfg_wdata_i[DW-1:0];
        REG_T2_MASK: t2_mask_q <= cfg_wdata_i[DW-1:0];
        REG_PRELOAD: preload_q <= cfg_wdata_i[CW-1:0];
        default: ;
      endcase
    end
  end

  // event pulses registered to line up with comparator hits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      dbg_q <= active & dbg_ev_i;
      ovf_q <= active & ovf_ev_i;
    end
  end

  brk_addr_trig #(.AW(AW)) u_t1 (
    .clk_i, .rst_ni, .en_i(active), .mode_i(ctrl_q.t1), .cmp_i(t1_cmp_q),
    .pab_i, .p_fetch_i, .p_rd_i, .p_wr_i, .xab_i, .x_rd_i, .x_wr_i,
    .hit_o(t1_hit)
  );

  brk_data_trig #(.DW(DW)) u_t2 (
    .clk_i, .rst_ni, .en_i(active), .mode_i(ctrl_q.t2), .val_i(t2_val_q),
    .mask_i(t2_mask_q), .rdata_i, .wdata_i, .x_rd_i, .x_wr_i,
    .hit_o(t2_hit)
  );

  always_comb begin
    case (ctrl_q.src)
      SRC_T1:  cnt_ev = t1_hit;
      SRC_T2:  cnt_ev = t2_hit;
      SRC_DBG: cnt_ev = dbg_q;
      default: cnt_ev = ovf_q;
    endcase
  end

  brk_evt_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .en_i(active), .load_i(arm_wr | cnt_reload),
    .preload_i(preload_q), .ev_i(cnt_ev), .fire_o(cnt_fire)
  );

  brk_combine u_cmb (
    .clk_i, .rst_ni, .act_i(active), .clr_arm_i(arm_wr), .mode_i(ctrl_q.cmb),
    .t1_i(t1_hit), .t2_i(t2_hit), .cnt_i(cnt_fire), .fire_o(cmb_fire)
  );

  assign irq_o       = cmb_fire & (ctrl_q.act == ACT_IRQ || ctrl_q.act == ACT_IRQ_RELOAD);
  assign trc_start_o = cmb_fire & (ctrl_q.act == ACT_TRC_START);
  assign trc_stop_o  = cmb_fire & (ctrl_q.act == ACT_TRC_STOP);
  assign halt_set    = cmb_fire & (ctrl_q.act == ACT_HALT);
  assign cnt_reload  = cmb_fire & (ctrl_q.act == ACT_IRQ_RELOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (ctrl_wr && !cfg_wdata_i[0]) halt_q <= 1'b0;
      else if (halt_set)              halt_q <= 1'b1;
      else if (halt_clr_i)            halt_q <= 1'b0;
      if (ctrl_wr)                    lock_q <= 1'b0;
      else if (halt_set)              lock_q <= 1'b1;
    end
  end

  assign halt_o = halt_q | halt_set;

  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !(irq_o || trc_start_o || trc_stop_o || halt_o)); // R11
  AST_HALT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !halt_clr_i && !ctrl_wr) |=> halt_o); // R10
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_o, trc_start_o, trc_stop_o, halt_set})); // R9
  AST_LOCK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> !(irq_o || trc_start_o || trc_stop_o)); // R10

endmodule

// File: tb/brk_unit_tb.sv
module brk_unit_tb;
  import brk_pkg::*;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [23:0] pab = '0, xab = '0;
  logic        p_fetch = 0, p_rd = 0, p_wr = 0, x_rd = 0, x_wr = 0;
  logic [31:0] rdata = '0, wdata = '0;
  logic        dbg_ev = 0, ovf_ev = 0, halt_clr = 0;
  logic        irq, trc_start, trc_stop, halt;
  int          nchk = 0, nerr = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  brk_unit u_dut (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .pab_i(pab), .p_fetch_i(p_fetch), .p_rd_i(p_rd),
    .p_wr_i(p_wr), .xab_i(xab), .x_rd_i(x_rd), .x_wr_i(x_wr), .rdata_i(rdata),
    .wdata_i(wdata), .dbg_ev_i(dbg_ev), .ovf_ev_i(ovf_ev), .halt_clr_i(halt_clr),
    .irq_o(irq), .trc_start_o(trc_start), .trc_stop_o(trc_stop), .halt_o(halt)
  );

  typedef struct packed {
    t1_mode_e    mode;
    logic [23:0] pa;
    logic [23:0] xa;
    logic        f, pr, pw, xr, xw;
    logic        exp;
  } vec_t;

  localparam logic [23:0] CMP = 24'h001234;
  localparam int NV = 14;
  // R1 program-side codes, R2 data-side codes
  localparam vec_t VECS [NV] = '{
    '{T1_P_FETCH, CMP,          24'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{T1_P_FETCH, CMP,          24'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{T1_P_READ,  CMP,          24'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{T1_P_WRITE, CMP,          24'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{T1_P_WRITE, 24'h001235,   24'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{T1_P_ANY,   CMP,          24'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{T1_P_ANY,   CMP,          24'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{T1_P_ANY,   24'h0,        CMP,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{T1_X_READ,  24'h0,        CMP,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{T1_X_READ,  24'h0,        CMP,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{T1_X_WRITE, 24'h0,        CMP,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{T1_X_ANY,   24'h0,        CMP,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{T1_X_ANY,   CMP,          24'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{T1_OFF,     CMP,          CMP,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  function automatic logic [31:0] mk(logic en, t1_mode_e t1, t2_mode_e t2,
                                     cmb_mode_e cmb, cnt_src_e src, act_e act);
    return {18'b0, act, src, cmb, t2, t1, en};
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic idle();
    pab = '0; xab = '0; p_fetch = 0; p_rd = 0; p_wr = 0; x_rd = 0; x_wr = 0;
    rdata = '0; wdata = '0; dbg_ev = 0; ovf_ev = 0;
  endtask

  // one active bus cycle, returns at the negedge of the following cycle
  task automatic cyc(logic [23:0] pa, logic [23:0] xa, logic f, logic pr, logic pw,
                     logic xr, logic xw, logic [31:0] rd, logic [31:0] wd,
                     logic dbg, logic ovf);
    @(negedge clk);
    pab = pa; xab = xa; p_fetch = f; p_rd = pr; p_wr = pw; x_rd = xr; x_wr = xw;
    rdata = rd; wdata = wd; dbg_ev = dbg; ovf_ev = ovf;
    @(negedge clk); idle();
  endtask

  task automatic wdat(logic [31:0] wd, logic [23:0] xa);
    cyc(24'h0, xa, 0, 0, 0, 0, 1, 32'h0, wd, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset halt", halt, 0);
    chk("R11 reset trc", trc_start | trc_stop, 0);

    // table walk: R1 / R2
    for (int i = 0; i < NV; i++) begin
      cfg(REG_T1_CMP, {8'h0, CMP});
      cfg(REG_CTRL, mk(1, VECS[i].mode, T2_OFF, CMB_T1, SRC_T1, ACT_IRQ));
      cyc(VECS[i].pa, VECS[i].xa, VECS[i].f, VECS[i].pr, VECS[i].pw,
          VECS[i].xr, VECS[i].xw, 32'h0, 32'h0, 0, 0);
      chk(VECS[i].mode >= T1_X_READ ? "R2 vector" : "R1 vector", irq, VECS[i].exp);
    end

    // R2 peripheral address
    cfg(REG_T1_CMP, 32'h00FFFF00);
    cfg(REG_CTRL, mk(1, T1_X_WRITE, T2_OFF, CMB_T1, SRC_T1, ACT_IRQ));
    wdat(32'h0, 24'hFFFF00);
    chk("R2 peripheral", irq, 1);

    // R4 timing: nothing in the bus cycle itself, one-cycle pulse after it
    cfg(REG_T1_CMP, {8'h0, CMP});
    cfg(REG_CTRL, mk(1, T1_P_FETCH, T2_OFF, CMB_T1, SRC_T1, ACT_IRQ));
    @(negedge clk); pab = CMP; p_fetch = 1;
    #1 chk("R4 same cycle", irq, 0);
    @(negedge clk); idle();
    chk("R4 next cycle", irq, 1);
    @(negedge clk);
    chk("R4 pulse width", irq, 0);

    // R3 masked data compare
    cfg(REG_T2_VAL, 32'hA5A50000);
    cfg(REG_T2_MASK, 32'hFFFF0000);
    cfg(REG_CTRL, mk(1, T1_OFF, T2_READ, CMB_T2, SRC_T1, ACT_IRQ));
    cyc(0, 24'h10, 0, 0, 0, 1, 0, 32'hA5A51234, 32'h0, 0, 0);
    chk("R3 read masked match", irq, 1);
    cyc(0, 24'h10, 0, 0, 0, 1, 0, 32'hA5A40000, 32'h0, 0, 0);
    chk("R3 read mismatch", irq, 0);
    cyc(0, 24'h10, 0, 0, 0, 0, 1, 32'h0, 32'hA5A5FFFF, 0, 0);
    chk("R3 write ignored in read mode", irq, 0);
    cfg(REG_CTRL, mk(1, T1_OFF, T2_WRITE, CMB_T2, SRC_T1, ACT_IRQ));
    wdat(32'hA5A5FFFF, 24'h10);
    chk("R3 write match", irq, 1);
    cyc(0, 24'h10, 0, 0, 0, 1, 0, 32'hA5A50000, 32'h0, 0, 0);
    chk("R3 read ignored in write mode", irq, 0);

    // R5 AND / OR
    cfg(REG_CTRL, mk(1, T1_X_WRITE, T2_WRITE, CMB_AND, SRC_T1, ACT_IRQ));
    wdat(32'hA5A50000, CMP);
    chk("R5 and both", irq, 1);
    wdat(32'h0, CMP);
    chk("R5 and t1 only", irq, 0);
    wdat(32'hA5A50000, 24'h10);
    chk("R5 and t2 only", irq, 0);
    cfg(REG_CTRL, mk(1, T1_X_WRITE, T2_WRITE, CMB_OR, SRC_T1, ACT_IRQ));
    wdat(32'hA5A50000, 24'h10);
    chk("R5 or t2 only", irq, 1);
    wdat(32'h0, CMP);
    chk("R5 or t1 only", irq, 1);

    // R6 sequence
    cfg(REG_CTRL, mk(1, T1_X_WRITE, T2_WRITE, CMB_SEQ, SRC_T1, ACT_IRQ));
    wdat(32'hA5A50000, 24'h10);
    chk("R6 t2 before arm", irq, 0);
    wdat(32'h0, CMP);
    chk("R6 t1 arms", irq, 0);
    wdat(32'hA5A50000, 24'h10);
    chk("R6 t2 after arm", irq, 1);
    wdat(32'hA5A50000, 24'h10);
    chk("R6 armed consumed", irq, 0);
    wdat(32'h0, CMP);
    cfg(REG_CTRL, mk(1, T1_X_WRITE, T2_WRITE, CMB_SEQ, SRC_T1, ACT_IRQ));
    wdat(32'hA5A50000, 24'h10);
    chk("R6 arm cleared by arming write", irq, 0);

    // R7 counter
    cfg(REG_PRELOAD, 32'd3);
    cfg(REG_CTRL, mk(1, T1_OFF, T2_OFF, CMB_CNT, SRC_DBG, ACT_IRQ));
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R7 ev1", irq, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R7 ev2", irq, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R7 ev3 fires", irq, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R7 stays zero", irq, 0);
    cfg(REG_PRELOAD, 32'd0);
    cfg(REG_CTRL, mk(1, T1_OFF, T2_OFF, CMB_CNT, SRC_DBG, ACT_IRQ));
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R7 preload zero", irq, 0);

    // R9 reload action: periodic
    cfg(REG_PRELOAD, 32'd2);
    cfg(REG_CTRL, mk(1, T1_OFF, T2_OFF, CMB_CNT, SRC_DBG, ACT_IRQ_RELOAD));
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R9 reload ev1", irq, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R9 reload ev2", irq, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R9 reload ev3", irq, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R9 reload ev4", irq, 1);

    // R8 source select
    cfg(REG_PRELOAD, 32'd1);
    cfg(REG_CTRL, mk(1, T1_OFF, T2_OFF, CMB_CNT, SRC_OVF, ACT_IRQ));
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk("R8 dbg unselected", irq, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); chk("R8 ovf counted", irq, 1);
    cfg(REG_PRELOAD, 32'd2);
    cfg(REG_CTRL, mk(1, T1_P_FETCH, T2_OFF, CMB_CNT, SRC_T1, ACT_IRQ));
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0); chk("R8 t1 ev1", irq, 0);
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0); chk("R8 t1 ev2", irq, 1);

    // R9 trace actions
    cfg(REG_CTRL, mk(1, T1_P_FETCH, T2_OFF, CMB_T1, SRC_T1, ACT_TRC_START));
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 trace start", trc_start, 1);
    chk("R9 no irq on trace", irq, 0);
    cfg(REG_CTRL, mk(1, T1_P_FETCH, T2_OFF, CMB_T1, SRC_T1, ACT_TRC_STOP));
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 trace stop", trc_stop, 1);
    chk("R9 no start on stop", trc_start, 0);

    // R10 halt hold, clear, lock
    cfg(REG_CTRL, mk(1, T1_P_FETCH, T2_OFF, CMB_T1, SRC_T1, ACT_HALT));
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 halt asserts", halt, 1);
    repeat (3) @(negedge clk);
    chk("R10 halt held", halt, 1);
    halt_clr = 1; @(negedge clk); halt_clr = 0;
    chk("R10 halt cleared", halt, 0);
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 locked ignores trigger", halt, 0);
    cfg(REG_CTRL, mk(1, T1_P_FETCH, T2_OFF, CMB_T1, SRC_T1, ACT_HALT));
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 rearmed halt", halt, 1);

    // R11 disable
    cfg(REG_CTRL, mk(0, T1_P_FETCH, T2_OFF, CMB_T1, SRC_T1, ACT_HALT));
    chk("R11 disable drops halt", halt, 0);
    cfg(REG_CTRL, mk(0, T1_P_FETCH, T2_OFF, CMB_T1, SRC_T1, ACT_IRQ));
    cyc(CMP, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 disabled irq", irq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule